// File: doc/BRIEF.md
# Vectored Branch Opcode Generator

This block sits on the instruction fetch return path between a processor core and its memory. When the core fetches the normal-interrupt exception address and vectored dispatch is switched on, the block does not return the stored memory word. It returns a freshly built unconditional branch opcode instead. That branch lands on the vector slot that belongs to the interrupt source which currently wins arbitration. The core therefore skips any software search for the pending source and goes straight to that source's slot.

The branch offset is PC-relative. It is computed from the slot address stored in a parameterised vector table and from the fetch address: the word offset is (target − fetch address − 8) shifted right by two, and the low 24 bits of it go into the opcode under the fixed top byte 0xEA. The winning source index is captured together with the fetch strobe. The substituted word appears on the data cycle that follows. Every other fetch, including the fast-interrupt exception address, passes memory data through unchanged.

Top module: `vbog_top`

## Requirements
- R1: After reset is released, and with no fetch strobe, `cpu_rdata` equals `mem_rdata` in every cycle.
- R2: A strobe at address `IRQ_ADDR` (default 0x18), with `vec_en`=1, `win_valid`=1 and `win_idx` below `NUM_SRC`, makes `cpu_rdata` in the next cycle equal to 0xEA000000 + (((T − IRQ_ADDR − 8) >> 2) & 0xFFFFFF). Here T is table entry `win_idx`, and the default table gives entry i the value 0x20 + 4·i.
- R3: A winner whose table target is 0x20, fetched from 0x18, yields exactly 0xEA000000.
- R4: With `IRQ_ADDR`=0x60 and a target of 0x10000, the substituted word is 0xEA003FE6.
- R5: A strobe at `FIQ_ADDR` (default 0x1C) never substitutes: the next-cycle `cpu_rdata` equals `mem_rdata`.
- R6: With `vec_en`=0 at the strobe, the IRQ fetch returns `mem_rdata`.
- R7: With `win_valid`=0 at the strobe, the IRQ fetch returns `mem_rdata`.
- R8: The winner index is taken at the strobe cycle. A change of `win_idx`, `win_valid` or `vec_en` in the data cycle does not alter the returned opcode.
- R9: A target below the fetch address gives a negative offset, kept as 24-bit two's complement. With slot 0x60 and target 0x0 the result is 0xEAFFFFE6.
- R10: Substitution lasts only the single cycle after the strobe. The cycle after that returns `mem_rdata` again.
- R11: A valid winner index of `NUM_SRC` or higher is treated as no winner, and the fetch returns `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Fetch strobe, address phase |
| fetch_addr | input | 32 | Fetch address, sampled with the strobe |
| mem_rdata | input | 32 | Memory read data, valid in the cycle after the strobe |
| win_idx | input | IDX_W | Index of the winning normal-interrupt source |
| win_valid | input | 1 | Winner index is meaningful |
| vec_en | input | 1 | Vectored dispatch enable |
| cpu_rdata | output | 32 | Read data returned to the core |

## Verification
A wrong captured substitute flag shows at the port in the data cycle that follows a strobe. It appears either as a branch word where memory data was due or as raw memory data where a branch was due, so it is visible one cycle after the faulty capture. A wrong captured opcode shows in that same cycle as a branch to the wrong slot; sweeping every table entry with distinct targets exposes an index or offset fault. A flag that lingers is seen one cycle later, when the word after the branch still differs from memory data.

// File: rtl/vbog_pkg.sv
package vbog_pkg;

    localparam int MAX_SRC = 32;
    localparam logic [31:0] BRANCH_BASE = 32'hEA00_0000;
    localparam logic [31:0] OFFSET_MASK = 32'h00FF_FFFF;

    typedef logic [MAX_SRC-1:0][31:0] vec_table_t;

    function automatic vec_table_t linear_table(logic [31:0] base, logic [31:0] stride);
        vec_table_t t;
        for (int i = 0; i < MAX_SRC; i++) begin
            t[i] = base + stride * 32'(i);
        end
        return t;
    endfunction

endpackage

// File: rtl/vbog_lookup.sv
module vbog_lookup
    import vbog_pkg::*;
#(
    parameter int         NUM_SRC   = 26,
    parameter vec_table_t VEC_TABLE = linear_table(32'h20, 32'h4),
    localparam int        IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      target,
    output logic             in_range
);

    always_comb begin
        target   = 32'h0;
        in_range = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (32'(idx) == 32'(i)) begin
                target   = VEC_TABLE[i];
                in_range = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vbog_encoder.sv
module vbog_encoder
    import vbog_pkg::*;
(
    input  logic [31:0] target,
    input  logic [31:0] slot,
    output logic [31:0] opcode
);

    logic [31:0] diff;

    always_comb begin
        diff   = target - slot - 32'd8;
        opcode = BRANCH_BASE + ((diff >> 2) & OFFSET_MASK);
    end

endmodule

// File: rtl/vbog_top.sv
module vbog_top
    import vbog_pkg::*;
#(
    parameter int          NUM_SRC   = 26,
    parameter logic [31:0] IRQ_ADDR  = 32'h18,
    parameter logic [31:0] FIQ_ADDR  = 32'h1C,
    parameter vec_table_t  VEC_TABLE = linear_table(32'h20, 32'h4),
    localparam int         IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_req,
    input  logic [31:0]      fetch_addr,
    input  logic [31:0]      mem_rdata,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             win_valid,
    input  logic             vec_en,
    output logic [31:0]      cpu_rdata
);

    typedef struct packed {
        logic        sub;
        logic [31:0] op;
    } state_t;

    state_t state_d, state_q;

    logic [31:0] tgt;
    logic        in_range;
    logic [31:0] opcode;

    vbog_lookup #(
        .NUM_SRC   (NUM_SRC),
        .VEC_TABLE (VEC_TABLE)
    ) u_lookup (
        .idx      (win_idx),
        .target   (tgt),
        .in_range (in_range)
    );

    vbog_encoder u_enc (
        .target (tgt),
        .slot   (IRQ_ADDR),
        .opcode (opcode)
    );

    always_comb begin
        state_d     = state_q;
        state_d.sub = 1'b0;
        if (fetch_req) begin
            state_d.sub = (fetch_addr == IRQ_ADDR) && vec_en && win_valid && in_range;
            state_d.op  = opcode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_rdata = state_q.sub ? state_q.op : mem_rdata;

    p_fiq_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_addr == FIQ_ADDR && FIQ_ADDR != IRQ_ADDR) |=> (cpu_rdata == mem_rdata));

    p_disabled_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !vec_en) |=> (cpu_rdata == mem_rdata));

    p_invalid_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !win_valid) |=> (cpu_rdata == mem_rdata));

    p_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_req |=> (cpu_rdata == mem_rdata));

    p_branch_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_addr == IRQ_ADDR && vec_en && win_valid && 32'(win_idx) < 32'(NUM_SRC))
        |=> (cpu_rdata[31:24] == 8'hEA));

endmodule

// File: tb/vbog_top_tb.sv
module vbog_top_tb;
    import vbog_pkg::*;

    localparam int IDX_W = 5;

    function automatic vec_table_t tb_table2();
        vec_table_t t;
        t    = '0;
        t[0] = 32'h0001_0000;
        t[1] = 32'h0000_0000;
        return t;
    endfunction

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fetch_req = 1'b0;
    logic [31:0]      fetch_addr = '0;
    logic [31:0]      mem_rdata = '0;
    logic [IDX_W-1:0] win_idx = '0;
    logic             win_valid = 1'b0;
    logic             vec_en = 1'b0;
    logic [31:0]      cpu_rdata, cpu_rdata2;
    logic             idx2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign idx2 = win_idx[0];

    vbog_top u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .mem_rdata(mem_rdata), .win_idx(win_idx), .win_valid(win_valid),
        .vec_en(vec_en), .cpu_rdata(cpu_rdata)
    );

    vbog_top #(
        .NUM_SRC(2), .IRQ_ADDR(32'h60), .VEC_TABLE(tb_table2())
    ) u_dut2 (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .mem_rdata(mem_rdata), .win_idx(idx2), .win_valid(win_valid),
        .vec_en(vec_en), .cpu_rdata(cpu_rdata2)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_op(logic [31:0] tgt, logic [31:0] slot);
        logic [31:0] off;
        off = (tgt - slot - 32'd8) >> 2;
        return 32'hEA00_0000 | {8'h00, off[23:0]};
    endfunction

    // Strobe in one cycle, data cycle next; optionally disturb winner inputs in the data cycle.
    task automatic fetch(input logic [31:0] addr, input logic en, input logic vld,
                         input logic [IDX_W-1:0] idx, input logic [31:0] mem,
                         input bit disturb, output logic [31:0] r1, output logic [31:0] r2);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = addr;
        vec_en     = en;
        win_valid  = vld;
        win_idx    = idx;
        @(negedge clk);
        fetch_req  = 1'b0;
        mem_rdata  = mem;
        if (disturb) begin
            win_idx   = ~idx;
            win_valid = ~vld;
            vec_en    = ~en;
        end
        #1;
        r1 = cpu_rdata;
        r2 = cpu_rdata2;
    endtask

    task automatic t_reset();
        @(negedge clk);
        mem_rdata = 32'h1234_5678;
        #1 check("R1 reset pass-through", cpu_rdata, 32'h1234_5678);
        @(negedge clk);
        mem_rdata = 32'hCAFE_0001;
        #1 check("R1 idle pass-through", cpu_rdata, 32'hCAFE_0001);
    endtask

    task automatic t_sweep();
        logic [31:0] r, r2;
        for (int i = 0; i < 26; i++) begin
            fetch(32'h18, 1'b1, 1'b1, IDX_W'(i), 32'hDEAD_0000 + 32'(i), 1'b0, r, r2);
            check($sformatf("R2 vector idx %0d", i), r, expect_op(32'h20 + 32'(4 * i), 32'h18));
        end
    endtask

    task automatic t_first_slot();
        logic [31:0] r, r2;
        fetch(32'h18, 1'b1, 1'b1, '0, 32'h5555_5555, 1'b0, r, r2);
        check("R3 slot 0x20 opcode", r, 32'hEA00_0000);
    endtask

    task automatic t_selfcheck();
        logic [31:0] r, r2;
        fetch(32'h60, 1'b1, 1'b1, '0, 32'h7777_7777, 1'b0, r, r2);
        check("R4 target 0x10000 from 0x60", r2, 32'hEA00_3FE6);
        check("R4 other dut passes", r, 32'h7777_7777);
    endtask

    task automatic t_negative();
        logic [31:0] r, r2;
        fetch(32'h60, 1'b1, 1'b1, 5'd1, 32'h1111_2222, 1'b0, r, r2);
        check("R9 negative offset", r2, 32'hEAFF_FFE6);
    endtask

    task automatic t_fiq();
        logic [31:0] r, r2;
        fetch(32'h1C, 1'b1, 1'b1, 5'd3, 32'hF1F1_F1F1, 1'b0, r, r2);
        check("R5 FIQ fetch pass-through", r, 32'hF1F1_F1F1);
    endtask

    task automatic t_disabled();
        logic [31:0] r, r2;
        fetch(32'h18, 1'b0, 1'b1, 5'd4, 32'hAB00_0004, 1'b0, r, r2);
        check("R6 vectored disabled", r, 32'hAB00_0004);
    endtask

    task automatic t_invalid();
        logic [31:0] r, r2;
        fetch(32'h18, 1'b1, 1'b0, 5'd4, 32'hAB00_0005, 1'b0, r, r2);
        check("R7 no valid winner", r, 32'hAB00_0005);
    endtask

    task automatic t_midfetch();
        logic [31:0] r, r2;
        fetch(32'h18, 1'b1, 1'b1, 5'd7, 32'h0BAD_0BAD, 1'b1, r, r2);
        check("R8 index held from strobe", r, expect_op(32'h20 + 32'd28, 32'h18));
    endtask

    task automatic t_single();
        logic [31:0] r, r2;
        fetch(32'h18, 1'b1, 1'b1, 5'd9, 32'h0, 1'b0, r, r2);
        check("R10 substitute cycle", r, expect_op(32'h20 + 32'd36, 32'h18));
        @(negedge clk);
        mem_rdata = 32'h600D_600D;
        #1 check("R10 following cycle pass-through", cpu_rdata, 32'h600D_600D);
    endtask

    task automatic t_range();
        logic [31:0] r, r2;
        fetch(32'h18, 1'b1, 1'b1, 5'd30, 32'hEE00_001E, 1'b0, r, r2);
        check("R11 index out of range", r, 32'hEE00_001E);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sweep();
        t_first_slot();
        t_selfcheck();
        t_negative();
        t_fiq();
        t_disabled();
        t_invalid();
        t_midfetch();
        t_single();
        t_range();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule